// File: doc/BRIEF.md
# CAN Transmit Mailbox Request Arbiter

This block decides which of a bank of CAN mailboxes hands its frame to the bit-level CAN engine next. Every mailbox carries a pending-send flag and a payload-hold flag. Software raises pending-send flags through a small register port. The hold flags are a plain read/write vector, and a mailbox whose hold flag is set is kept out of selection until software clears it. The top mailbox index is receive-only and is never offered. Mailboxes can also be armed to answer remote frames automatically. A remote-frame match on an armed mailbox raises its pending-send flag, so the reply goes through the same hold masking and selection as a software request.

While the engine is idle, the lowest-indexed mailbox that is pending and not held is offered on a valid/ready start channel. The offer tracks eligibility until the engine accepts it. Because no transmission has begun before acceptance, setting a hold flag may withdraw the offer. Once the offer is accepted, the mailbox index is latched and no new offer is made until the engine reports done or lost arbitration. A hold raised during this time does not abort the frame. On done, the pending flag of the latched mailbox is cleared and its acknowledge flag is set. On lost arbitration the pending flag stays set and selection runs again on the next cycle. The remote-match input has no back-pressure: it is sampled every cycle it is valid.

Register select codes are 0 for pending-send (writing 1 sets a bit, writing 0 has no effect), 1 for hold (read/write), 2 for remote-reply arm (read/write) and 3 for acknowledge (writing 1 clears a bit). In every vector, bit k belongs to mailbox k, and the bit of the receive-only mailbox always reads 0.

Top module: `can_txreq_arbiter`

## Requirements
- R1: After reset, all four register vectors read 0 and tx_valid is 0.
- R2: A write with select 0 sets each pending-send bit whose data bit is 1. Data bits that are 0 leave pending bits unchanged. Bit 31 (the receive-only mailbox) always reads 0.
- R3: The hold vector (select 1) reads back the value written, except that bit 31 always reads 0.
- R4: A mailbox whose pending and hold bits are both 1 is never offered. tx_valid is 0 when no mailbox is both pending and un-held.
- R5: While the engine is idle, tx_valid is 1 when some mailbox below 31 is pending and un-held, and tx_idx is the lowest such index.
- R6: After the cycle in which tx_valid and tx_ready are both 1, tx_valid stays 0 until tx_done or tx_lost. Setting the hold bit of the mailbox in flight does not stop done from completing it.
- R7: tx_done clears the pending bit of the accepted mailbox and sets its acknowledge bit. A write with select 3 clears each acknowledge bit whose data bit is 1.
- R8: tx_lost leaves the pending bit set, and the same mailbox is offered again in the following cycle when it is still the lowest eligible one.
- R9: A cycle with rmt_valid high sets the pending bit of mailbox rmt_idx only if its remote-reply arm bit is 1. Any other remote match changes nothing.
- R10: Clearing a hold bit puts the mailbox back into selection while its pending bit is still set.
- R11: The remote-reply arm vector (select 2) reads back the value written, except that bit 31 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for the write (0 pending, 1 hold, 2 arm, 3 acknowledge) |
| reg_wr_data | input | 32 | Write data, one bit per mailbox |
| reg_rd_sel | input | 2 | Register select for the read, same codes as the write |
| reg_rd_data | output | 32 | Read data of the selected vector, combinational |
| rmt_valid | input | 1 | Remote-frame match present this cycle |
| rmt_idx | input | 5 | Mailbox index of the remote-frame match |
| tx_valid | output | 1 | Start offer to the CAN engine |
| tx_ready | input | 1 | Engine accepts the offer |
| tx_idx | output | 5 | Offered mailbox index |
| tx_done | input | 1 | Accepted frame completed |
| tx_lost | input | 1 | Accepted frame lost arbitration |

## Verification
On every cycle, the assertions check that an offered mailbox is pending, un-held and not the receive-only one. They also check that no offer appears right after acceptance, that done leaves the acknowledge bit set, that lost arbitration keeps the request pending, and that bit 31 of the hold readback is 0. The lowest-index priority, the withdrawal and return of an offer as hold bits change, the arming rule for remote replies, and the write-1 semantics of the pending and acknowledge vectors can only be shown by the bench. It sweeps every single mailbox and every pair of transmittable mailboxes and compares against expected values computed from the indices.

// File: rtl/can_txreq_pkg.sv
package can_txreq_pkg;
  typedef enum logic [1:0] {
    SEL_REQ  = 2'd0,
    SEL_HOLD = 2'd1,
    SEL_AUTO = 2'd2,
    SEL_ACK  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/can_txreq_regs.sv
module can_txreq_regs #(
  parameter int NUM_MBOX = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_sel,
  input  logic [NUM_MBOX-1:0]         wr_data,
  input  logic [1:0]                  rd_sel,
  output logic [NUM_MBOX-1:0]         rd_data,
  input  logic                        rmt_valid,
  input  logic [$clog2(NUM_MBOX)-1:0] rmt_idx,
  input  logic                        fin_done,
  input  logic                        fin_lost,
  input  logic [$clog2(NUM_MBOX)-1:0] fin_idx,
  output logic [NUM_MBOX-1:0]         req_o,
  output logic [NUM_MBOX-1:0]         hold_o
);
  import can_txreq_pkg::*;

  localparam int IDX_W = $clog2(NUM_MBOX);
  localparam logic [NUM_MBOX-1:0] ONE     = {{(NUM_MBOX-1){1'b0}}, 1'b1};
  localparam logic [NUM_MBOX-1:0] TX_MASK = {1'b0, {(NUM_MBOX-1){1'b1}}};

  logic [NUM_MBOX-1:0] req_q, hold_q, auto_q, ack_q;
  logic [NUM_MBOX-1:0] done_vec, rmt_vec, sw_set, ack_clr;
  logic [NUM_MBOX-1:0] req_d, hold_d, auto_d, ack_d;
  reg_sel_e wsel, rsel;

  assign wsel = reg_sel_e'(wr_sel);
  assign rsel = reg_sel_e'(rd_sel);

  assign done_vec = fin_done ? (ONE << fin_idx) : '0;
  assign rmt_vec  = rmt_valid ? ((ONE << rmt_idx) & auto_q) : '0;
  assign sw_set   = (wr_en && wsel == SEL_REQ) ? wr_data : '0;
  assign ack_clr  = (wr_en && wsel == SEL_ACK) ? wr_data : '0;

  always_comb begin
    req_d  = ((req_q & ~done_vec) | sw_set | rmt_vec) & TX_MASK;
    hold_d = (wr_en && wsel == SEL_HOLD) ? (wr_data & TX_MASK) : hold_q;
    auto_d = (wr_en && wsel == SEL_AUTO) ? (wr_data & TX_MASK) : auto_q;
    ack_d  = ((ack_q & ~ack_clr) | done_vec) & TX_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      hold_q <= '0;
      auto_q <= '0;
      ack_q  <= '0;
    end else begin
      req_q  <= req_d;
      hold_q <= hold_d;
      auto_q <= auto_d;
      ack_q  <= ack_d;
    end
  end

  always_comb begin
    case (rsel)
      SEL_REQ:  rd_data = req_q;
      SEL_HOLD: rd_data = hold_q;
      SEL_AUTO: rd_data = auto_q;
      default:  rd_data = ack_q;
    endcase
  end

  assign req_o  = req_q;
  assign hold_o = hold_q;

  // R7
  ack_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_done |=> ack_q[$past(fin_idx)]);

  // R8
  lost_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_lost |=> req_q[$past(fin_idx)]);

  // R3
  hold_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd1) |-> !rd_data[NUM_MBOX-1]);

  logic [IDX_W-1:0] unused_idx;
  assign unused_idx = '0;
endmodule

// File: rtl/can_txreq_select.sv
module can_txreq_select #(
  parameter int NUM_MBOX = 32
) (
  input  logic [NUM_MBOX-1:0]         req,
  input  logic [NUM_MBOX-1:0]         hold,
  output logic                        any,
  output logic [$clog2(NUM_MBOX)-1:0] idx
);
  localparam int IDX_W = $clog2(NUM_MBOX);

  logic [NUM_MBOX-1:0] elig;

  assign elig[NUM_MBOX-1] = 1'b0;
  for (genvar g = 0; g < NUM_MBOX - 1; g++) begin : g_elig
    assign elig[g] = req[g] & ~hold[g];
  end

  assign any = |elig;

  always_comb begin
    idx = '0;
    for (int k = NUM_MBOX - 1; k >= 0; k--) begin
      if (elig[k]) idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/can_txreq_seq.sv
module can_txreq_seq #(
  parameter int NUM_MBOX = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        any,
  input  logic [$clog2(NUM_MBOX)-1:0] sel_idx,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  output logic [$clog2(NUM_MBOX)-1:0] tx_idx,
  input  logic                        tx_done,
  input  logic                        tx_lost,
  output logic                        fin_done,
  output logic                        fin_lost,
  output logic [$clog2(NUM_MBOX)-1:0] fin_idx
);
  localparam int IDX_W = $clog2(NUM_MBOX);

  logic             busy_q;
  logic [IDX_W-1:0] cur_q;
  logic             accept;

  assign tx_valid = !busy_q && any;
  assign tx_idx   = sel_idx;
  assign accept   = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cur_q  <= sel_idx;
    end else if (busy_q && (tx_done || tx_lost)) begin
      busy_q <= 1'b0;
    end
  end

  assign fin_done = busy_q && tx_done;
  assign fin_lost = busy_q && tx_lost && !tx_done;
  assign fin_idx  = cur_q;

  // R6
  no_offer_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);
endmodule

// File: rtl/can_txreq_arbiter.sv
module can_txreq_arbiter #(
  parameter int NUM_MBOX = 32,
  parameter int IDX_W    = $clog2(NUM_MBOX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [1:0]          reg_wr_sel,
  input  logic [NUM_MBOX-1:0] reg_wr_data,
  input  logic [1:0]          reg_rd_sel,
  output logic [NUM_MBOX-1:0] reg_rd_data,
  input  logic                rmt_valid,
  input  logic [IDX_W-1:0]    rmt_idx,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [IDX_W-1:0]    tx_idx,
  input  logic                tx_done,
  input  logic                tx_lost
);
  logic [NUM_MBOX-1:0] req_v, hold_v;
  logic                any;
  logic [IDX_W-1:0]    sel_idx, fin_idx;
  logic                fin_done, fin_lost;

  can_txreq_regs #(.NUM_MBOX(NUM_MBOX)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
    .rmt_valid(rmt_valid), .rmt_idx(rmt_idx),
    .fin_done(fin_done), .fin_lost(fin_lost), .fin_idx(fin_idx),
    .req_o(req_v), .hold_o(hold_v)
  );

  can_txreq_select #(.NUM_MBOX(NUM_MBOX)) u_sel (
    .req(req_v), .hold(hold_v), .any(any), .idx(sel_idx)
  );

  can_txreq_seq #(.NUM_MBOX(NUM_MBOX)) u_seq (
    .clk(clk), .rst_n(rst_n), .any(any), .sel_idx(sel_idx),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idx(tx_idx),
    .tx_done(tx_done), .tx_lost(tx_lost),
    .fin_done(fin_done), .fin_lost(fin_lost), .fin_idx(fin_idx)
  );

  // R4
  offer_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (req_v[tx_idx] && !hold_v[tx_idx] && (tx_idx != IDX_W'(NUM_MBOX-1))));
endmodule

// File: tb/can_txreq_arbiter_bench.sv
module can_txreq_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_sel = '0;
  logic [31:0] reg_rd_data;
  logic        rmt_valid = 1'b0;
  logic [4:0]  rmt_idx = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [4:0]  tx_idx;
  logic        tx_done = 1'b0;
  logic        tx_lost = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  can_txreq_arbiter u_can_txreq_arbiter (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .rmt_valid(rmt_valid), .rmt_idx(rmt_idx),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idx(tx_idx),
    .tx_done(tx_done), .tx_lost(tx_lost)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [31:0] v);
    reg_rd_sel = sel;
    #1;
    v = reg_rd_data;
  endtask

  task automatic pulse_ready();
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1; tick(); tx_done = 1'b0;
  endtask

  task automatic pulse_lost();
    tx_lost = 1'b1; tick(); tx_lost = 1'b0;
  endtask

  task automatic pulse_rmt(logic [4:0] idx);
    rmt_valid = 1'b1; rmt_idx = idx; tick(); rmt_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pair;
    tick();
    do_reset();
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v); chk("R1 vector after reset", v, 32'h0);
    end
    chk("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);

    // R2 write-1 sets, write-0 no effect, R3/R11 top bit reads 0
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 set all", v, 32'h7FFF_FFFF);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R2 write zero no effect", v, 32'h7FFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R3 hold readback", v, 32'h7FFF_FFFF);
    wr(2'd1, 32'h0000_A5A5);
    rd(2'd1, v); chk("R3 hold pattern", v, 32'h0000_A5A5);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R11 arm readback", v, 32'h7FFF_FFFF);

    // R5 R7 R2 sweep over every single mailbox
    for (int i = 0; i < 32; i++) begin
      do_reset();
      wr(2'd0, 32'h1 << i);
      rd(2'd0, v); chk("R2 single request", v, (i == 31) ? 32'h0 : (32'h1 << i));
      chk("R5 single valid", {31'b0, tx_valid}, (i == 31) ? 32'h0 : 32'h1);
      if (i != 31) begin
        chk("R5 single idx", {27'b0, tx_idx}, 32'(i));
        pulse_ready();
        #1; chk("R6 no offer in flight", {31'b0, tx_valid}, 32'h0);
        pulse_done();
        rd(2'd0, v); chk("R7 request cleared", v, 32'h0);
        rd(2'd3, v); chk("R7 ack set", v, 32'h1 << i);
        wr(2'd3, 32'h1 << i);
        rd(2'd3, v); chk("R7 ack cleared", v, 32'h0);
      end
    end

    // R4 R5 R10 sweep over every pair of transmittable mailboxes
    for (int i = 0; i < 31; i++) begin
      for (int j = i + 1; j < 31; j++) begin
        pair = (32'h1 << i) | (32'h1 << j);
        do_reset();
        wr(2'd0, pair);
        #1; chk("R5 pair lowest", {27'b0, tx_idx}, 32'(i));
        wr(2'd1, 32'h1 << i);
        #1; chk("R4 held lowest skipped", {27'b0, tx_idx}, 32'(j));
        wr(2'd1, pair);
        #1; chk("R4 all held no offer", {31'b0, tx_valid}, 32'h0);
        wr(2'd1, 32'h0);
        #1; chk("R10 hold released valid", {31'b0, tx_valid}, 32'h1);
        chk("R10 hold released idx", {27'b0, tx_idx}, 32'(i));
      end
    end

    // R8 lost arbitration
    do_reset();
    wr(2'd0, 32'h28);
    pulse_ready();
    pulse_lost();
    #1;
    chk("R8 re-offer valid", {31'b0, tx_valid}, 32'h1);
    chk("R8 re-offer idx", {27'b0, tx_idx}, 32'd3);
    rd(2'd0, v); chk("R8 request kept", v, 32'h28);
    rd(2'd3, v); chk("R8 no ack", v, 32'h0);

    // R6 hold raised during transmission does not abort
    do_reset();
    wr(2'd0, 32'h4);
    pulse_ready();
    wr(2'd1, 32'h4);
    pulse_done();
    rd(2'd0, v); chk("R6 in-flight completes req", v, 32'h0);
    rd(2'd3, v); chk("R6 in-flight completes ack", v, 32'h4);

    // R9 R11 remote reply sweep
    for (int i = 0; i < 32; i++) begin
      do_reset();
      wr(2'd2, 32'h1 << i);
      rd(2'd2, v); chk("R11 arm single", v, (i == 31) ? 32'h0 : (32'h1 << i));
      pulse_rmt(5'((i + 1) % 32));
      rd(2'd0, v); chk("R9 unarmed match ignored", v, 32'h0);
      pulse_rmt(5'(i));
      rd(2'd0, v); chk("R9 armed match sets req", v, (i == 31) ? 32'h0 : (32'h1 << i));
      if (i != 31) begin
        chk("R9 reply offered", {27'b0, tx_idx}, 32'(i));
      end
    end

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule